// File: doc/BRIEF.md
# Multi-channel completion status FIFO

This block collects command-completion reports from up to four storage channels and keeps them, in order of acceptance, in one shared queue. Software drains the queue through a simple register read port. Each queued entry holds the number of the channel that finished, a 6-bit host status code and the 8-bit device status byte. The entry is read as two 32-bit words. The high word carries an empty flag and a valid flag in its top two bits, so a single read of that word reports the completion and also tells the driver whether to keep draining. Reading the high word removes the head entry. Reading the low word changes nothing.

Each channel delivers its report over a valid/ready stream. A channel raises `ch_valid` with its status fields and must hold the valid bit and the fields steady until it sees `ch_ready` high at a clock edge. The report is accepted at that edge. When several channels report together, a round-robin arbiter accepts one per cycle. When the queue is full, no channel sees ready and every report waits in its channel, so nothing is ever lost. A single interrupt line is high while the queue holds an entry and the global interrupt enable is set.

Top module: `cmpl_status_fifo`

## Requirements
- R1: After reset the queue is empty, `irq` is 0, the interrupt enable is clear, and a read of the high word returns 0x8000_0000.
- R2: A high-word read (offset 0x104) of a non-empty queue returns the fields of the head entry: bit 31 = 0 (empty flag), bit 30 = 1 (valid flag), bits 9:8 = channel number, and bits 5:0 = host status code. Code 0 means success and code 3 means device error. All other bits are 0.
- R3: A low-word read (offset 0x100) returns the device status byte of the head entry in bits 23:16, with all other bits 0. It has no side effect, so repeating the read returns the same value.
- R4: A high-word read pops the head entry when the queue is not empty. On an empty queue it returns 0x8000_0000 and changes nothing.
- R5: Entries are read back in the order in which they were accepted.
- R6: At most one channel sees `ch_ready` in any cycle. Among the requesting channels, the search starts at the channel after the one last granted. The first search after reset starts at channel 0.
- R7: A channel that is not granted sees `ch_ready` low and is accepted in a later cycle. No report is lost or duplicated.
- R8: While the queue holds DEPTH entries, no channel sees `ch_ready`. A waiting channel is accepted in the cycle after a pop frees a slot.
- R9: A write to offset 0xE4 sets the interrupt enable if the byte is nonzero and clears it if the byte is zero. The change takes effect one cycle later. `irq` equals (queue not empty) AND (enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | NUM_CH | Per-channel report valid |
| ch_ready | output | NUM_CH | Per-channel report accepted this edge |
| ch_hst | input | NUM_CH*6 | Host status code, channel k in bits k*6 +: 6 |
| ch_dst | input | NUM_CH*8 | Device status byte, channel k in bits k*8 +: 8 |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 32 | Read data, combinational from address and head entry |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that every channel follows the stream rule: once it raises valid, it keeps valid and its status fields unchanged until it is accepted. They also assume the register port issues single-cycle strobes. The stimulus holds each report until the bench sees ready before the clock edge, and changes a channel's fields only after acceptance. Each read or write is driven as one strobe away from the edge. The full-queue case keeps a report waiting across several cycles, so the hold rule is exercised while the channel is stalled.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
  localparam int HST_W      = 6;
  localparam int DST_W      = 8;
  localparam int CH_FIELD_W = 2;

  localparam logic [11:0] OFS_WORD_LO = 12'h100;
  localparam logic [11:0] OFS_WORD_HI = 12'h104;
  localparam logic [11:0] OFS_IRQ_EN  = 12'h0E4;

  localparam int HI_EMPTY_BIT = 31;
  localparam int HI_VALID_BIT = 30;
  localparam int HI_CH_LSB    = 8;
  localparam int LO_DST_LSB   = 16;

  localparam logic [HST_W-1:0] HST_OK      = 6'd0;
  localparam logic [HST_W-1:0] HST_DEV_ERR = 6'd3;

  typedef struct packed {
    logic [CH_FIELD_W-1:0] chan;
    logic [HST_W-1:0]      hst;
    logic [DST_W-1:0]      dst;
  } cmpl_entry_t;
endpackage

// File: rtl/cmpl_rr_arb.sv
module cmpl_rr_arb #(
  parameter int N = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic [N-1:0]                       req,
  output logic [N-1:0]                       grant,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] grant_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int unsigned j;
      j = (int'(last_q) + k) % N;
      if (!found && en && req[j]) begin
        found     = 1'b1;
        grant[j]  = 1'b1;
        grant_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= IW'(N - 1);
    else if (found) last_q <= grant_idx;
  end
endmodule

// File: rtl/cmpl_store.sv
module cmpl_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_q;
  logic          do_push, do_pop;

  assign empty   = (occ_q == '0);
  assign full    = (occ_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rd_ptr];
  assign occ     = occ_q;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/cmpl_status_fifo.sv
module cmpl_status_fifo
  import cmpl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_valid,
  output logic [NUM_CH-1:0]       ch_ready,
  input  logic [NUM_CH*HST_W-1:0] ch_hst,
  input  logic [NUM_CH*DST_W-1:0] ch_dst,
  input  logic                    reg_rd,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    irq
);
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int EW = $bits(cmpl_entry_t);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NUM_CH-1:0] grant;
  logic [IW-1:0]     grant_idx;
  logic              empty, full;
  logic [CW-1:0]     occ;
  logic              irq_en_q;
  cmpl_entry_t       in_entry, head;
  logic [EW-1:0]     head_bits;
  logic              sel_lo, sel_hi, sel_en, pop;

  cmpl_rr_arb #(.N(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (!full),
    .req       (ch_valid),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  assign ch_ready = grant;

  always_comb begin
    in_entry      = '0;
    in_entry.chan = CH_FIELD_W'(grant_idx);
    for (int k = 0; k < NUM_CH; k++) begin
      if (grant[k]) begin
        in_entry.hst = ch_hst[k*HST_W +: HST_W];
        in_entry.dst = ch_dst[k*DST_W +: DST_W];
      end
    end
  end

  assign sel_lo = (reg_addr == ADDR_W'(OFS_WORD_LO));
  assign sel_hi = (reg_addr == ADDR_W'(OFS_WORD_HI));
  assign sel_en = (reg_addr == ADDR_W'(OFS_IRQ_EN));
  assign pop    = reg_rd && sel_hi;

  cmpl_store #(.W(EW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (|grant),
    .wdata (in_entry),
    .pop   (pop),
    .head  (head_bits),
    .occ   (occ),
    .empty (empty),
    .full  (full)
  );

  assign head = cmpl_entry_t'(head_bits);

  always_comb begin
    reg_rdata = '0;
    if (sel_hi) begin
      reg_rdata[HI_EMPTY_BIT] = empty;
      if (!empty) begin
        reg_rdata[HI_VALID_BIT]                       = 1'b1;
        reg_rdata[HI_CH_LSB +: CH_FIELD_W]            = head.chan;
        reg_rdata[HST_W-1:0]                          = head.hst;
      end
    end else if (sel_lo && !empty) begin
      reg_rdata[LO_DST_LSB +: DST_W] = head.dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               irq_en_q <= 1'b0;
    else if (reg_wr && sel_en) irq_en_q <= |reg_wdata;
  end

  assign irq = !empty && irq_en_q;
endmodule

// File: rtl/cmpl_status_fifo_chk.sv
module cmpl_status_fifo_chk #(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CH-1:0]          ch_valid,
  input logic [NUM_CH-1:0]          ch_ready,
  input logic [NUM_CH*6-1:0]        ch_hst,
  input logic [NUM_CH*8-1:0]        ch_dst,
  input logic                       reg_rd,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [7:0]                 reg_wdata,
  input logic [31:0]                reg_rdata,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic                       irq_en_q
);
  localparam int CW = $clog2(DEPTH + 1);
  logic rd_hi, wr_en_off;
  assign rd_hi     = reg_rd && (reg_addr == ADDR_W'(12'h104));
  assign wr_en_off = reg_wr && (reg_addr == ADDR_W'(12'h0E4)) && (reg_wdata == 8'h00);

  p_empty_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && occ == '0 |-> reg_rdata == 32'h8000_0000);

  p_valid_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && occ != '0 |-> reg_rdata[31:30] == 2'b01);

  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && occ != '0 && ch_ready == '0 |=> occ == $past(occ) - 1'b1);

  p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_ready));

  p_accept_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready != '0 && !rd_hi |=> occ == $past(occ) + 1'b1);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ == CW'(DEPTH) |-> ch_ready == '0);

  p_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_irq_needs_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> occ != '0 && irq_en_q);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_off |=> !irq);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
    p_hold_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ch_valid[g] && !ch_ready[g] |=> ch_valid[g] && $stable(ch_hst[g*6 +: 6])
                                      && $stable(ch_dst[g*8 +: 8]));
  end
endmodule

bind cmpl_status_fifo cmpl_status_fifo_chk #(
  .NUM_CH (NUM_CH),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_valid  (ch_valid),
  .ch_ready  (ch_ready),
  .ch_hst    (ch_hst),
  .ch_dst    (ch_dst),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .occ       (occ),
  .irq_en_q  (irq_en_q)
);

// File: tb/tb_cmpl_status_fifo.sv
module tb_cmpl_status_fifo;
  localparam int NCH = 4;
  localparam int DEP = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  ch_valid = '0;
  logic [NCH-1:0]  ch_ready;
  logic [NCH*6-1:0] ch_hst = '0;
  logic [NCH*8-1:0] ch_dst = '0;
  logic            reg_rd = 1'b0, reg_wr = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic [7:0]      reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cmpl_status_fifo #(.NUM_CH(NCH), .DEPTH(DEP), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .ch_hst(ch_hst), .ch_dst(ch_dst), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {channel, host code, device byte}
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 6'h00, 8'h50}, {2'd1, 6'h03, 8'h51}, {2'd2, 6'h00, 8'hFF},
    {2'd3, 6'h3F, 8'h00}, {2'd3, 6'h00, 8'hA5}, {2'd0, 6'h15, 8'h5A},
    {2'd2, 6'h03, 8'h41}, {2'd1, 6'h2A, 8'hC3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hi_word(input int c, input logic [5:0] h);
    return 32'h4000_0000 | (32'(c) << 8) | 32'(h);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input int c, input logic [5:0] h, input logic [7:0] d);
    @(negedge clk);
    ch_valid[c] = 1'b1;
    ch_hst[c*6 +: 6] = h;
    ch_dst[c*8 +: 8] = d;
    #1;
    while (!ch_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    ch_valid[c] = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1: reset state
    #1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(12'h104, v);
    check("R1 empty read", v, 32'h8000_0000);

    // Vector walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      int c;
      c = int'(VEC[i][15:14]);
      push(c, VEC[i][13:8], VEC[i][7:0]);
      rd(12'h100, v);
      check("R3 low word", v, {8'h00, VEC[i][7:0], 16'h0000});
      rd(12'h100, v);
      check("R3 low word repeat", v, {8'h00, VEC[i][7:0], 16'h0000});
      rd(12'h104, v);
      check("R2 high word", v, hi_word(c, VEC[i][13:8]));
      rd(12'h104, v);
      check("R4 popped to empty", v, 32'h8000_0000);
    end

    // R9: interrupt gating
    push(2, 6'h03, 8'h77);
    #1 check("R9 disabled", {31'b0, irq}, 32'h0);
    wr(12'h0E4, 8'h01);
    check("R9 enabled", {31'b0, irq}, 32'h1);
    wr(12'h0E4, 8'h00);
    check("R9 cleared", {31'b0, irq}, 32'h0);
    wr(12'h0E4, 8'h01);
    check("R9 re-enabled", {31'b0, irq}, 32'h1);
    rd(12'h104, v);
    check("R9 entry", v, hi_word(2, 6'h03));
    check("R9 drops when empty", {31'b0, irq}, 32'h0);
    rd(12'h104, v);
    check("R4 empty read no change", v, 32'h8000_0000);

    // R6 R7: round robin from reset
    do_reset();
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      ch_valid[k] = 1'b1;
      ch_hst[k*6 +: 6] = 6'(k + 1);
      ch_dst[k*8 +: 8] = 8'(8'h10 + k);
    end
    for (int k = 0; k < 4; k++) begin
      #1 check("R6 grant order", {28'b0, ch_ready}, 32'(1 << k));
      @(negedge clk);
      ch_valid[k] = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      rd(12'h104, v);
      check("R7 no loss order", v, hi_word(k, 6'(k + 1)));
    end
    // last grant was 3: ch1 then ch3 then ch1 again
    @(negedge clk);
    ch_valid[1] = 1'b1; ch_hst[6 +: 6] = 6'h21;
    ch_valid[3] = 1'b1; ch_hst[18 +: 6] = 6'h23;
    #1 check("R6 wrap start", {28'b0, ch_ready}, 32'h2);
    @(negedge clk);
    ch_hst[6 +: 6] = 6'h31;
    #1 check("R6 rotate past", {28'b0, ch_ready}, 32'h8);
    @(negedge clk);
    ch_valid[3] = 1'b0;
    #1 check("R7 held then accepted", {28'b0, ch_ready}, 32'h2);
    @(negedge clk);
    ch_valid[1] = 1'b0;
    rd(12'h104, v); check("R5 order a", v, hi_word(1, 6'h21));
    rd(12'h104, v); check("R5 order b", v, hi_word(3, 6'h23));
    rd(12'h104, v); check("R5 order c", v, hi_word(1, 6'h31));

    // R8: full queue stalls without loss
    for (int i = 0; i < DEP; i++) push(1, 6'(i), 8'(i));
    @(negedge clk);
    ch_valid[2] = 1'b1; ch_hst[12 +: 6] = 6'h3F; ch_dst[16 +: 8] = 8'hEE;
    for (int i = 0; i < 3; i++) begin
      #1 check("R8 stalled when full", {31'b0, ch_ready[2]}, 32'h0);
      @(negedge clk);
    end
    rd(12'h104, v);
    check("R8 head while full", v, hi_word(1, 6'h00));
    check("R8 ready after pop", {31'b0, ch_ready[2]}, 32'h1);
    @(posedge clk);
    #1 ch_valid[2] = 1'b0;
    for (int i = 1; i < DEP; i++) begin
      rd(12'h104, v);
      check("R5 drain", v, hi_word(1, 6'(i)));
    end
    rd(12'h100, v);
    check("R8 stalled entry byte", v, 32'h00EE_0000);
    rd(12'h104, v);
    check("R8 stalled entry", v, hi_word(2, 6'h3F));
    rd(12'h104, v);
    check("R4 final empty", v, 32'h8000_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule